// File: doc/BRIEF.md
# Serial Presence Detect Byte Reader

This block fetches a single byte from a memory module's configuration EEPROM over an open-drain two-wire bus. Software writes one 32-bit command word. The word names the device class, the 3-bit bus address of the target module and the byte offset. The engine then runs the complete random-read transaction on the bus without further help and posts the outcome in a 16-bit status word that software polls.

The bus address is normally formed as channel × 4 + slot, so one engine can reach every module position on two channels. SCL timing comes from the system clock. A parameter sets the length of a quarter bit period in clock cycles, so the bus runs at `f_clk / (4 × QUARTER_CYC)` plus a few cycles between symbols. The engine drives each line only by pulling it low. The data line is read back through `sda_in`.

Top module: `spd_read_engine`

## Requirements
- R1: After a synchronous active-low reset, `status` reads 0 and neither bus line is pulled low.
- R2: A write of `cmd_word` with bit 0 = 0 (read) while not busy is taken. On the next clock, busy (status bit 12) is 1, and done (bit 15) and error (bit 13) are both 0.
- R3: A command write that arrives while busy is 1 is ignored. The running transaction finishes with the result of the command that started it.
- R4: A command with bit 0 = 1 (write request) never starts a transaction, and status keeps its previous value.
- R5: The bus sequence is: START; device byte {bits 31:28, bits 26:24, 0}; offset byte (bits 23:16); repeated START; device byte with the last bit 1; one data byte; master NACK; STOP. On success, done = 1, error = 0 and status bits 7:0 hold the byte read.
- R6: If any of the three address bytes is not acknowledged, the engine issues STOP. It then ends with error = 1, done = 0 and status bits 7:0 = 0.
- R7: Every SCL high pulse within a transaction, other than the final STOP, lasts exactly 2 × QUARTER_CYC clock cycles.
- R8: Whenever busy is 0, both bus lines are released.
- R9: A command write that is held through the cycle in which a transaction ends is ignored in that cycle. It is taken on the following cycle, so busy is low for exactly one cycle and the first result is visible in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command: [31:28] device class, [27] clock override (unused), [26:24] bus address, [23:16] byte offset, [15:8] write data (unused), [0] 0 = read |
| sda_in | input | 1 | Sensed level of the data line |
| status | output | 16 | [15] done, [13] error, [12] busy, [7:0] data byte; other bits 0 |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| sda_drive_low | output | 1 | 1 pulls the data line low |

## Verification
Two functions can meet in the same clock: the end of a transaction (busy falling, result posted) and the acceptance of a new command. The bench provokes this by raising the strobe with a second command while the first read is still running, and holding it there until busy drops. The scoreboard must then see the first result in the single cycle where busy is low, and busy high again on the next cycle. The second read must then complete with its own byte. The ignore-while-busy rule is judged the same way, because the transaction must return the byte for the offset that started it and not the one written later.

// File: rtl/spd_pkg.sv
// Shared definitions for the presence-detect byte reader.
// Assumes: status and command bit positions are fixed by software.
package spd_pkg;
    localparam int ST_DONE_BIT  = 15;
    localparam int ST_ERR_BIT   = 13;
    localparam int ST_BUSY_BIT  = 12;
    localparam int CMD_RW_BIT   = 0;
    localparam int CMD_OFS_LSB  = 16;
    localparam int CMD_ADR_LSB  = 24;
    localparam int CMD_CLS_LSB  = 28;

    // Bus symbols the line driver can produce
    typedef enum logic [1:0] {
        SYM_START = 2'd0,
        SYM_STOP  = 2'd1,
        SYM_BIT   = 2'd2
    } bus_sym_e;

    // Byte-level steps of the random-read transaction
    typedef enum logic [3:0] {
        SQ_IDLE, SQ_START1, SQ_DEVW, SQ_ACK1, SQ_ADDR, SQ_ACK2,
        SQ_START2, SQ_DEVR, SQ_ACK3, SQ_DATA, SQ_MNACK, SQ_STOP
    } seq_st_e;
endpackage

// File: rtl/spd_tick_gen.sv
// Quarter-bit tick generator.
// Emits one-cycle pulses every PERIOD clocks while run is high;
// restarts from zero whenever run drops, so each symbol starts aligned.
module spd_tick_gen #(
    parameter int PERIOD = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(PERIOD - 1));

    // Count cycles inside a quarter period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spd_line_phy.sv
// Line driver for one bus symbol (START, STOP or one data bit).
// Each symbol is four quarter periods long. For a bit, SDA is set in
// quarter 0, SCL is high in quarters 1-2, and SDA is sampled at the
// end of quarter 2. Outputs are registered and hold between symbols.
// Assumes: go arrives only while busy is low; no clock stretching.
module spd_line_phy
    import spd_pkg::*;
#(
    parameter int QUARTER = 125
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go,
    input  bus_sym_e sym,
    input  logic     wbit,
    input  logic     sda_in,
    output logic     busy,
    output logic     done,
    output logic     rx_bit,
    output logic     scl_pull,
    output logic     sda_pull
);
    localparam int HCW = $clog2(2 * QUARTER + 2) + 1;

    logic       tick;
    logic [1:0] phase;
    bus_sym_e   sym_q;
    logic       wbit_q;
    logic       scl_rel, sda_rel;

    spd_tick_gen #(.PERIOD(QUARTER)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    // Symbol sequencing: latch the request, step quarters, sample, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            phase  <= 2'd0;
            sym_q  <= SYM_STOP;
            wbit_q <= 1'b1;
            rx_bit <= 1'b1;
        end else begin
            done <= 1'b0;
            if (!busy && go) begin
                busy   <= 1'b1;
                phase  <= 2'd0;
                sym_q  <= sym;
                wbit_q <= wbit;
            end else if (busy && tick) begin
                if (phase == 2'd2 && sym_q == SYM_BIT) rx_bit <= sda_in;
                if (phase == 2'd3) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
                phase <= phase + 2'd1;
            end
        end
    end

    // Line levels wanted in the current quarter
    always_comb begin
        unique case (sym_q)
            SYM_START: begin
                scl_rel = (phase == 2'd1) || (phase == 2'd2);
                sda_rel = (phase <= 2'd1);
            end
            SYM_STOP: begin
                scl_rel = (phase != 2'd0);
                sda_rel = (phase >= 2'd2);
            end
            default: begin
                scl_rel = (phase == 2'd1) || (phase == 2'd2);
                sda_rel = wbit_q;
            end
        endcase
    end

    // Output registers: updated only during a symbol, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pull <= 1'b0;
            sda_pull <= 1'b0;
        end else if (busy) begin
            scl_pull <= ~scl_rel;
            sda_pull <= ~sda_rel;
        end
    end

    // Checker state: length of the current SCL high stretch within a symbol
    logic [HCW-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) hi_cnt <= '0;
        else if (busy && !scl_pull && sym_q != SYM_STOP) hi_cnt <= hi_cnt + 1'b1;
        else hi_cnt <= '0;
    end

    p_scl_high_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= HCW'(2 * QUARTER));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/spd_read_seq.sv
// Byte-level sequencer for one random read.
// Issues START, device byte (write), offset, repeated START, device
// byte (read), eight data bits, master NACK and STOP, one symbol at a
// time. A missing acknowledge jumps straight to STOP and raises nack.
// Assumes: start arrives only in idle; dev_id and offset stay stable.
module spd_read_seq
    import spd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [6:0] dev_id,
    input  logic [7:0] offset,
    input  logic       sym_done,
    input  logic       rx_bit,
    output logic       go,
    output bus_sym_e   sym,
    output logic       wbit,
    output logic       fin,
    output logic       nack,
    output logic [7:0] rx_byte
);
    seq_st_e    st;
    logic [2:0] bitn;
    logic [7:0] txb;

    // Byte being shifted out in the current send step
    always_comb begin
        unique case (st)
            SQ_DEVW: txb = {dev_id, 1'b0};
            SQ_ADDR: txb = offset;
            default: txb = {dev_id, 1'b1};
        endcase
    end

    // Step through the transaction one symbol per completed symbol
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            bitn    <= 3'd0;
            go      <= 1'b0;
            sym     <= SYM_STOP;
            wbit    <= 1'b1;
            fin     <= 1'b0;
            nack    <= 1'b0;
            rx_byte <= 8'd0;
        end else begin
            go  <= 1'b0;
            fin <= 1'b0;
            if (st == SQ_IDLE) begin
                if (start) begin
                    st   <= SQ_START1;
                    go   <= 1'b1;
                    sym  <= SYM_START;
                    nack <= 1'b0;
                end
            end else if (sym_done) begin
                go   <= 1'b1;
                sym  <= SYM_BIT;
                wbit <= 1'b1;
                unique case (st)
                    SQ_START1, SQ_START2: begin
                        st   <= (st == SQ_START1) ? SQ_DEVW : SQ_DEVR;
                        bitn <= 3'd7;
                        wbit <= dev_id[6];
                    end
                    SQ_DEVW, SQ_ADDR, SQ_DEVR: begin
                        if (bitn != 3'd0) begin
                            bitn <= bitn - 3'd1;
                            wbit <= txb[bitn - 3'd1];
                        end else begin
                            st <= (st == SQ_DEVW) ? SQ_ACK1 :
                                  (st == SQ_ADDR) ? SQ_ACK2 : SQ_ACK3;
                        end
                    end
                    SQ_ACK1, SQ_ACK2, SQ_ACK3: begin
                        if (rx_bit) begin
                            nack <= 1'b1;
                            st   <= SQ_STOP;
                            sym  <= SYM_STOP;
                        end else if (st == SQ_ACK1) begin
                            st   <= SQ_ADDR;
                            bitn <= 3'd7;
                            wbit <= offset[7];
                        end else if (st == SQ_ACK2) begin
                            st  <= SQ_START2;
                            sym <= SYM_START;
                        end else begin
                            st   <= SQ_DATA;
                            bitn <= 3'd7;
                        end
                    end
                    SQ_DATA: begin
                        rx_byte <= {rx_byte[6:0], rx_bit};
                        if (bitn != 3'd0) bitn <= bitn - 3'd1;
                        else              st   <= SQ_MNACK;
                    end
                    SQ_MNACK: begin
                        st  <= SQ_STOP;
                        sym <= SYM_STOP;
                    end
                    SQ_STOP: begin
                        st  <= SQ_IDLE;
                        go  <= 1'b0;
                        fin <= 1'b1;
                    end
                    default: st <= SQ_IDLE;
                endcase
            end
        end
    end

    p_fin_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (st == SQ_IDLE));
endmodule

// File: rtl/spd_read_engine.sv
// Presence-detect byte reader, top level.
// Holds the command and status registers, accepts read commands while
// idle and posts done/error/data when the sequencer finishes.
// Assumes: an open-drain bus with external pull-ups; one target.
module spd_read_engine
    import spd_pkg::*;
#(
    parameter int QUARTER_CYC = 125
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_word,
    input  logic        sda_in,
    output logic [15:0] status,
    output logic        scl_drive_low,
    output logic        sda_drive_low
);
    logic       busy_q, done_q, err_q, start_q;
    logic [7:0] data_q;
    logic [6:0] dev_q;
    logic [7:0] ofs_q;
    logic       accept;

    logic       seq_go, seq_wbit, seq_fin, seq_nack;
    bus_sym_e   seq_sym;
    logic [7:0] seq_byte;
    logic       phy_busy, phy_done, phy_rx;

    logic unused_cmd_bits;
    assign unused_cmd_bits = ^{cmd_word[27], cmd_word[15:1]};

    assign accept = cmd_wr && !busy_q && !cmd_word[CMD_RW_BIT];

    // Command capture and result posting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            start_q <= 1'b0;
            data_q  <= 8'd0;
            dev_q   <= 7'd0;
            ofs_q   <= 8'd0;
        end else begin
            start_q <= accept;
            if (accept) begin
                busy_q <= 1'b1;
                done_q <= 1'b0;
                err_q  <= 1'b0;
                dev_q  <= {cmd_word[CMD_CLS_LSB +: 4], cmd_word[CMD_ADR_LSB +: 3]};
                ofs_q  <= cmd_word[CMD_OFS_LSB +: 8];
            end else if (seq_fin) begin
                busy_q <= 1'b0;
                done_q <= !seq_nack;
                err_q  <= seq_nack;
                data_q <= seq_nack ? 8'd0 : seq_byte;
            end
        end
    end

    assign status = {done_q, 1'b0, err_q, busy_q, 4'b0000, data_q};

    spd_read_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_q),
        .dev_id  (dev_q),
        .offset  (ofs_q),
        .sym_done(phy_done),
        .rx_bit  (phy_rx),
        .go      (seq_go),
        .sym     (seq_sym),
        .wbit    (seq_wbit),
        .fin     (seq_fin),
        .nack    (seq_nack),
        .rx_byte (seq_byte)
    );

    spd_line_phy #(.QUARTER(QUARTER_CYC)) u_phy (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (seq_go),
        .sym     (seq_sym),
        .wbit    (seq_wbit),
        .sda_in  (sda_in),
        .busy    (phy_busy),
        .done    (phy_done),
        .rx_bit  (phy_rx),
        .scl_pull(scl_drive_low),
        .sda_pull(sda_drive_low)
    );

    p_accept_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_q && !done_q && !err_q);

    p_busy_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !seq_fin) |=> busy_q && $stable(dev_q) && $stable(ofs_q));

    p_write_cmd_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && cmd_wr && cmd_word[CMD_RW_BIT]) |=> !busy_q && $stable(status));

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && err_q));

    p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !scl_drive_low && !sda_drive_low && !phy_busy);
endmodule

// File: tb/tb_spd_read_engine.sv
`timescale 1ns/1ps
module tb_spd_read_engine;
    localparam int Q = 4;
    localparam logic [2:0] SLV_SA = 3'd5;   // channel 1, slot 1

    typedef struct {
        logic       done;
        logic       err;
        logic [7:0] data;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = 32'd0;
    logic [15:0] status;
    logic        scl_drive_low, sda_drive_low;
    logic        slv_pull = 1'b0;
    wire         scl_line = ~scl_drive_low;
    wire         sda_line = ~(sda_drive_low | slv_pull);

    int n_tests = 0;
    int n_fail  = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    spd_read_engine #(.QUARTER_CYC(Q)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_word     (cmd_word),
        .sda_in       (sda_line),
        .status       (status),
        .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low)
    );

    function automatic logic [7:0] mem_fn(input logic [7:0] a);
        return a * 8'd7 + 8'd3;
    endfunction

    function automatic logic [31:0] make_cmd(input logic [3:0] cls, input logic [2:0] sa,
                                             input logic [7:0] ofs, input logic rw);
        return {cls, 1'b0, sa, ofs, 8'h00, 7'd0, rw};
    endfunction

    function automatic exp_t exp_for(input logic [3:0] cls, input logic [2:0] sa,
                                     input logic [7:0] ofs, input string tag);
        exp_t e;
        e.tag = tag;
        if (cls == 4'hA && sa == SLV_SA) begin
            e.done = 1'b1; e.err = 1'b0; e.data = mem_fn(ofs);
        end else begin
            e.done = 1'b0; e.err = 1'b1; e.data = 8'd0;
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- EEPROM target model ----------------
    int         sst = 0;   // 0 idle,1 dev,2 offset,3 ack,4 send,5 master ack
    int         bcnt = 0;
    int         after = 0;
    logic [7:0] sh = 8'd0;
    logic [7:0] ptr = 8'd0;

    always @(negedge sda_line) if (scl_line === 1'b1) begin
        sst = 1; bcnt = 0; slv_pull = 1'b0;
    end
    always @(posedge sda_line) if (scl_line === 1'b1) begin
        sst = 0; slv_pull = 1'b0;
    end
    always @(posedge scl_line) begin
        if (sst == 1 || sst == 2) begin
            sh = {sh[6:0], sda_line};
            bcnt++;
        end else if (sst == 5) sst = 0;
    end
    always @(negedge scl_line) begin
        if ((sst == 1 || sst == 2) && bcnt == 8) begin
            bcnt = 0;
            if (sst == 1) begin
                if (sh[7:1] == {4'hA, SLV_SA}) begin
                    slv_pull = 1'b1; after = sh[0] ? 4 : 2; sst = 3;
                end else sst = 0;
            end else begin
                ptr = sh; slv_pull = 1'b1; after = 0; sst = 3;
            end
        end else if (sst == 3) begin
            slv_pull = 1'b0; sst = after; bcnt = 0;
            if (after == 4) begin
                sh = mem_fn(ptr); slv_pull = ~sh[7]; bcnt = 1;
            end
        end else if (sst == 4) begin
            if (bcnt == 8) begin
                slv_pull = 1'b0; sst = 5;
            end else begin
                slv_pull = ~sh[7 - bcnt]; bcnt++;
            end
        end
    end

    // ---------------- Scoreboard monitor ----------------
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (rst_n && prev_busy && !status[12]) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected completion", {16'd0, status}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({status[15], status[13], status[7:0]} == {e.done, e.err, e.data}, e.tag,
                      {22'd0, status[15], status[13], status[7:0]},
                      {22'd0, e.done, e.err, e.data});
            end
        end
        prev_busy = status[12];
    end

    // ---------------- SCL high-time monitor (R7) ----------------
    logic meas_en = 1'b0;
    logic seen_low = 1'b0;
    int   hi_len = 0, n_pulse = 0, n_bad = 0;
    always @(negedge clk) begin
        if (!meas_en || !status[12]) begin
            hi_len = 0; seen_low = 1'b0;
        end else if (!scl_line) begin
            if (seen_low && hi_len > 0) begin
                n_pulse++;
                if (hi_len != 2 * Q) n_bad++;
            end
            hi_len = 0; seen_low = 1'b1;
        end else if (seen_low) hi_len++;
    end

    // ---------------- Driver ----------------
    task automatic issue(input logic [3:0] cls, input logic [2:0] sa, input logic [7:0] ofs, input string tag);
        exp_q.push_back(exp_for(cls, sa, ofs, tag));
        cmd_word = make_cmd(cls, sa, ofs, 1'b0);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        check(status[12] && !status[15] && !status[13], "R2 accept sets busy, clears flags",
              {16'd0, status}, 32'h1000);
    endtask

    task automatic wait_idle();
        while (status[12]) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] snap;
        int low_cycles;
        repeat (4) @(negedge clk);
        check(status == 16'd0, "R1 status in reset", {16'd0, status}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 16'd0, "R1 status after reset", {16'd0, status}, 32'd0);
        check(scl_line && sda_line, "R1 lines released", {30'd0, scl_line, sda_line}, 32'd3);

        // R5 basic read with SCL timing measurement (R7)
        meas_en = 1'b1;
        issue(4'hA, SLV_SA, 8'h00, "R5 read offset 00");
        wait_idle();
        meas_en = 1'b0;
        check(n_pulse == 38 && n_bad == 0, "R7 SCL high pulses", n_pulse * 256 + n_bad, 38 * 256);
        check(scl_line && sda_line, "R8 lines released when idle", {30'd0, scl_line, sda_line}, 32'd3);

        issue(4'hA, SLV_SA, 8'hFF, "R5 read offset FF");
        wait_idle();
        issue(4'hA, SLV_SA, 8'h5A, "R5 read offset 5A");
        wait_idle();

        // R4 write request is ignored
        snap = status;
        cmd_word = make_cmd(4'hA, SLV_SA, 8'h12, 1'b1);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        check(status == snap, "R4 write command ignored", {16'd0, status}, {16'd0, snap});
        repeat (20) @(negedge clk);
        check(status == snap && scl_line && sda_line, "R4 no bus activity",
              {16'd0, status}, {16'd0, snap});

        // R3 command during busy is ignored
        issue(4'hA, SLV_SA, 8'h21, "R3 result of first command");
        repeat (30) @(negedge clk);
        cmd_word = make_cmd(4'hA, SLV_SA, 8'h99, 1'b0);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        check(status[12] == 1'b1, "R3 still busy after ignored write", {16'd0, status}, 32'h1000);
        wait_idle();

        // R6 missing acknowledge
        issue(4'hA, 3'd3, 8'h10, "R6 wrong slot");
        wait_idle();
        check(scl_line && sda_line, "R8 released after error", {30'd0, scl_line, sda_line}, 32'd3);
        issue(4'h3, SLV_SA, 8'h10, "R6 wrong device class");
        wait_idle();
        issue(4'hA, SLV_SA, 8'h80, "R5 read after error");
        wait_idle();

        // R9 command held across completion
        exp_q.push_back(exp_for(4'hA, SLV_SA, 8'h33, "R9 first result"));
        exp_q.push_back(exp_for(4'hA, SLV_SA, 8'h44, "R9 second result"));
        cmd_word = make_cmd(4'hA, SLV_SA, 8'h33, 1'b0);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_word = make_cmd(4'hA, SLV_SA, 8'h44, 1'b0);
        while (status[12]) @(negedge clk);
        low_cycles = 0;
        while (!status[12] && low_cycles < 4) begin
            low_cycles++;
            @(negedge clk);
        end
        cmd_wr = 1'b0;
        check(low_cycles == 1, "R9 busy low for one cycle", low_cycles, 1);
        check(!status[15] && !status[13], "R9 flags cleared on re-accept", {16'd0, status}, 32'h1000);
        wait_idle();

        check(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule